// File: doc/BRIEF.md
# Vertical Sweep Burst Generator

This block produces a self-timed burst of four-phase vertical transfer clocks. It is used to dump unwanted charge from a CCD vertical register at high speed, or to shift a frame quickly past an unused region. A single start pulse, together with a mode select and a count of line transfers, starts the burst. The block then steps the four phase outputs through a rotating, overlapping pattern. Every line transfer is made of four sub-intervals whose lengths in clocks are fixed parameters. When the last transfer ends, the block raises a done pulse and returns all phases low.

There are two timing families. The full sweep uses four equal sub-intervals of 38 clocks. The autofocus shift and autofocus sweep use sub-intervals that alternate between 48 and 80 clocks. In both sweep modes, every phase rise is held back by one clock so that the driver sees rising edges one clock late. The shift mode passes the nominal pattern through unchanged. Typical counts are 68 or 110 transfers for an autofocus shift and 75 or 116 for an autofocus sweep. A full-frame sweep covers 1560 transfers.

Top module: `vsw_burst_gen`

## Requirements
- R1: After reset, all four phase outputs are low and done_o is low.
- R2: phase_o bit 0 is V1, bit 1 V2, bit 2 V3 and bit 3 V4. Within a line transfer, the nominal pattern steps through four sub-intervals in a fixed order: V1+V2 high, then V2+V3, then V3+V4, then V4+V1. The first sub-interval begins in the cycle after the clock edge that accepts the start. Outside a burst all phases are low.
- R3: With mode_i = 0 (full sweep), each sub-interval lasts 38 clocks, so one line transfer takes 152 clocks.
- R4: With mode_i = 1, 2 or 3 (autofocus families), the sub-intervals last 48, 80, 48 and 80 clocks in that order, so one line transfer takes 256 clocks.
- R5: In modes 0, 2 and 3 (sweep), a phase that rises in the nominal pattern goes high one clock later at phase_o, and falls at the nominal time. In mode 1 (shift), phase_o equals the nominal pattern.
- R6: A burst runs exactly lines_i line transfers. done_o is high for exactly one clock, in the cycle after the final sub-interval. All phases are low in that cycle.
- R7: A start pulse that arrives while a burst is running is ignored. The mode and count captured at acceptance stay in force until the burst ends.
- R8: A start pulse with lines_i = 0 is ignored. No burst runs, no done pulse appears, and the phases stay low.
- R9: V1 and V3 are never high together, and V2 and V4 are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst start request, sampled on the rising edge |
| mode_i | input | 2 | 0 full sweep, 1 autofocus shift, 2 or 3 autofocus sweep |
| lines_i | input | LINES_W | Number of line transfers in the burst |
| phase_o | output | 4 | Vertical phases, bit 0 = V1 through bit 3 = V4 |
| done_o | output | 1 | One-clock pulse when the burst ends |

## Verification
The edge that accepts the start is counted as cycle minus one. Sample k of the nominal pattern then lies in cycle k. In sweep modes, a delayed phase shows up one cycle later as the AND of samples k and k-1. done_o is due exactly in cycle lines × line_length. The bench drives inputs and samples outputs on the falling edge, starting with the first falling edge after the accepting edge. It compares every cycle of each burst, plus the two cycles after it, against an arithmetic model of sub-interval position. Ignored starts (during a burst, or with a zero count) are checked by continuing to compare the original burst cycle by cycle, or by watching the idle outputs for a window after the pulse.

// File: rtl/vsw_pkg.sv
package vsw_pkg;
  typedef enum logic [1:0] {
    VSW_FULL_SWEEP = 2'd0,
    VSW_AF_SHIFT   = 2'd1,
    VSW_AF_SWEEP   = 2'd2,
    VSW_AF_SWEEP_B = 2'd3
  } vsw_mode_e;

  // pair of adjacent phases high in sub-interval s
  function automatic logic [3:0] phase_pair(input logic [1:0] s);
    logic [7:0] dbl;
    dbl = {4'b0011, 4'b0011} << s;
    return dbl[3:0] | dbl[7:4];
  endfunction
endpackage

// File: rtl/vsw_step_timer.sv
module vsw_step_timer #(
  parameter int FULL_LEN  = 38,
  parameter int SHORT_LEN = 48,
  parameter int LONG_LEN  = 80
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       run_i,
  input  logic       split_i,
  output logic [1:0] sub_o,
  output logic       line_end_o
);
  localparam int MAX_AF  = (LONG_LEN > SHORT_LEN) ? LONG_LEN : SHORT_LEN;
  localparam int MAX_LEN = (MAX_AF > FULL_LEN) ? MAX_AF : FULL_LEN;
  localparam int TICK_W  = $clog2(MAX_LEN);

  logic [TICK_W-1:0] tick_q, last_tick;
  logic [1:0]        sub_q;
  logic              step_end;

  always_comb begin
    if (split_i) last_tick = sub_q[0] ? TICK_W'(LONG_LEN - 1) : TICK_W'(SHORT_LEN - 1);
    else         last_tick = TICK_W'(FULL_LEN - 1);
  end

  assign step_end   = run_i && (tick_q == last_tick);
  assign line_end_o = step_end && (sub_q == 2'd3);
  assign sub_o      = sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      sub_q  <= '0;
    end else if (clear_i) begin
      tick_q <= '0;
      sub_q  <= '0;
    end else if (step_end) begin
      tick_q <= '0;
      sub_q  <= sub_q + 2'd1;
    end else if (run_i) begin
      tick_q <= tick_q + TICK_W'(1);
    end
  end
endmodule

// File: rtl/vsw_line_counter.sv
module vsw_line_counter #(
  parameter int LINES_W = 11
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [LINES_W-1:0] lines_i,
  input  logic               line_end_i,
  output logic               busy_o,
  output logic               done_o
);
  logic [LINES_W-1:0] remain_q;
  logic               busy_q, done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        remain_q <= lines_i;
        busy_q   <= 1'b1;
      end else if (busy_q && line_end_i) begin
        if (remain_q == LINES_W'(1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          remain_q <= remain_q - LINES_W'(1);
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/vsw_phase_out.sv
module vsw_phase_out
  import vsw_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       busy_i,
  input  logic [1:0] sub_i,
  input  logic       delay_i,
  output logic [3:0] phase_o
);
  logic [3:0] nom, nom_q;

  assign nom = busy_i ? phase_pair(sub_i) : 4'b0000;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nom_q <= '0;
    else         nom_q <= nom;
  end

  // rising edges late by one clock, falling edges on time
  for (genvar g = 0; g < 4; g++) begin : g_ph
    assign phase_o[g] = delay_i ? (nom[g] & nom_q[g]) : nom[g];
  end
endmodule

// File: rtl/vsw_burst_gen.sv
module vsw_burst_gen
  import vsw_pkg::*;
#(
  parameter int LINES_W   = 11,
  parameter int FULL_LEN  = 38,
  parameter int SHORT_LEN = 48,
  parameter int LONG_LEN  = 80
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [1:0]         mode_i,
  input  logic [LINES_W-1:0] lines_i,
  output logic [3:0]         phase_o,
  output logic               done_o
);
  vsw_mode_e  mode_q;
  logic       busy, start_acc, line_end;
  logic [1:0] sub;

  assign start_acc = start_i && !busy && (lines_i != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= VSW_FULL_SWEEP;
    else if (start_acc) mode_q <= vsw_mode_e'(mode_i);
  end

  vsw_step_timer #(
    .FULL_LEN (FULL_LEN),
    .SHORT_LEN(SHORT_LEN),
    .LONG_LEN (LONG_LEN)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (start_acc),
    .run_i     (busy),
    .split_i   (mode_q != VSW_FULL_SWEEP),
    .sub_o     (sub),
    .line_end_o(line_end)
  );

  vsw_line_counter #(.LINES_W(LINES_W)) u_lines (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_acc),
    .lines_i   (lines_i),
    .line_end_i(line_end),
    .busy_o    (busy),
    .done_o    (done_o)
  );

  vsw_phase_out u_phase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (busy),
    .sub_i  (sub),
    .delay_i(mode_q != VSW_AF_SHIFT),
    .phase_o(phase_o)
  );
endmodule

// File: rtl/vsw_burst_gen_chk.sv
module vsw_burst_gen_chk #(
  parameter int LINES_W = 11
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [LINES_W-1:0] lines_i,
  input logic [3:0]         phase_o,
  input logic               done_o,
  input logic               busy,
  input logic [1:0]         mode_q
);
  a_r2_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> phase_o == 4'b0000);

  a_r6_idle_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> phase_o == 4'b0000);

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r6_done_ends_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy) && !busy));

  a_r7_mode_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i) |=> $stable(mode_q));

  a_r8_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy && lines_i == '0) |=> !busy);

  a_r9_no_opposite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phase_o[0] && phase_o[2]) && !(phase_o[1] && phase_o[3]));
endmodule

bind vsw_burst_gen vsw_burst_gen_chk #(.LINES_W(LINES_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .lines_i(lines_i),
  .phase_o(phase_o),
  .done_o (done_o),
  .busy   (busy),
  .mode_q (mode_q)
);

// File: tb/sim_vsw_burst_gen.sv
`timescale 1ns/1ps
module sim_vsw_burst_gen;
  localparam int LW = 11;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [1:0]    mode_i = 2'd0;
  logic [LW-1:0] lines_i = '0;
  logic [3:0]    phase_o;
  logic          done_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  vsw_burst_gen #(.LINES_W(LW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .lines_i(lines_i), .phase_o(phase_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int line_len(input int m);
    return (m == 0) ? 152 : 256;
  endfunction

  function automatic logic [3:0] exp_nom(input int m, input int lines, input int k);
    int o, s;
    if (k < 0 || k >= lines * line_len(m)) return 4'b0000;
    o = k % line_len(m);
    if (m == 0) s = o / 38;
    else s = (o < 48) ? 0 : (o < 128) ? 1 : (o < 176) ? 2 : 3;
    case (s)
      0: return 4'b0011;
      1: return 4'b0110;
      2: return 4'b1100;
      default: return 4'b1001;
    endcase
  endfunction

  // inj >= 0: drive a competing start in that cycle (R7)
  task automatic run_burst(input int m, input int lines, input int inj);
    int total;
    logic [3:0] e;
    string req;
    total = lines * line_len(m);
    @(negedge clk_i);
    start_i = 1'b1; mode_i = 2'(m); lines_i = LW'(lines);
    for (int k = 0; k <= total + 1; k++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      if (m == 1) e = exp_nom(m, lines, k);
      else        e = exp_nom(m, lines, k) & exp_nom(m, lines, k - 1);
      if (inj >= 0 && k > inj) req = "R7";
      else if (k < 2) req = "R2";
      else if (m != 1) req = "R5";
      else req = "R4";
      if (m == 0 && k >= 2 && inj < 0) req = "R3_R5";
      chk(phase_o == e, req, phase_o, e);
      chk(done_o == (k == total), "R6", done_o, (k == total));
      chk(!(phase_o[0] && phase_o[2]) && !(phase_o[1] && phase_o[3]), "R9", phase_o, 0);
      if (k == inj) begin
        start_i = 1'b1; mode_i = 2'((m + 1) % 4); lines_i = LW'(lines + 4);
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(phase_o == 4'b0 && done_o == 1'b0, "R1", {done_o, phase_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(phase_o == 4'b0 && done_o == 1'b0, "R1", {done_o, phase_o}, 0);

    // R3 R4 R5 R6: every mode, short counts
    for (int m = 0; m < 4; m++)
      for (int n = 1; n <= 3; n++)
        run_burst(m, n, -1);

    // typical autofocus counts
    run_burst(1, 68, -1);
    run_burst(2, 75, -1);

    // R7: competing start mid-burst
    run_burst(0, 5, 200);
    run_burst(1, 2, 300);

    // R8: zero count is ignored
    @(negedge clk_i);
    start_i = 1'b1; mode_i = 2'd1; lines_i = '0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      chk(phase_o == 4'b0 && done_o == 1'b0, "R8", {done_o, phase_o}, 0);
    end

    // back-to-back after a zero request
    run_burst(3, 1, -1);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule